// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to the two wires of an I2C bus and never drives them. Both lines pass through a synchroniser and are compared against their previous samples. A protocol state machine turns the edges it finds into a stream of typed events. Each event is a single-cycle pulse carrying a 4-bit code and an 8-bit value. The monitor follows 7-bit and 10-bit slave addressing and keeps the transfer direction given by the first address byte. For a 10-bit address it also outputs the assembled address.

The state machine has four states:
- `ST_FIND_START` waits for a START condition and then goes to `ST_FIND_ADDR`.
- `ST_FIND_ADDR` collects address bits on SCL rising edges. After eight bits it goes to `ST_FIND_ACK`.
- `ST_FIND_ACK` samples the acknowledge on the next SCL rising edge. It then goes back to `ST_FIND_ADDR` while address bytes remain, and goes to `ST_FIND_DATA` otherwise.
- `ST_FIND_DATA` collects data bits. After eight bits it goes to `ST_FIND_ACK`. A START goes to `ST_FIND_ADDR` as a repeated START, and a STOP goes to `ST_FIND_START`.

The system clock must run at least 8 times faster than SCL.

Top module: `i2c_bus_observer`

## Requirements
- R1: After a synchronous active-high reset, no event is produced, `addr10` reads 0 and `addr10_valid` is low. SCL pulses before any START produce no event.
- R2: A START is SDA falling while SCL was high in both the current and previous sample. An SCL rising edge in the same sample as an SDA edge is a data bit and never a START or STOP.
- R3: Event codes for conditions are 0 = START, 1 = repeated START and 2 = STOP. The first START after reset or after a STOP gives code 0. Every later START before the next STOP gives code 1.
- R4: A byte is built MSB first from 8 SCL rising edges. The 9th rising edge gives code 3 (ACK) when SDA is low and code 4 (NACK) when SDA is high. Condition and acknowledge events carry value 0.
- R5: Bit 0 of the first address byte after a START sets the direction, where 1 means read. Byte events use code 5 for address-read, 6 for address-write, 7 for data-read and 8 for data-write. Every byte up to the next START or STOP uses that direction.
- R6: With `shift_addr` = 1, a 7-bit address byte is reported right-shifted by one (for example 0xA2 becomes 0x51). With `shift_addr` = 0 it is reported unchanged.
- R7: A first address byte whose bits 7:3 equal 11110 starts a two-byte address phase. Both address bytes are reported unshifted with the address code for the latched direction.
- R8: For a 10-bit address, `addr10` = {first byte bits 2:1, second byte}. `addr10_valid` pulses in the same cycle as the acknowledge event of the second address byte.
- R9: In the address and acknowledge states, START and STOP conditions are ignored and only SCL rising edges count.
- R10: In the data state, any number of data bytes may follow. A START or STOP restarts or ends the transfer, and partly received data bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Asynchronous SCL line sample |
| sda_in | input | 1 | Asynchronous SDA line sample |
| shift_addr | input | 1 | 1: report 7-bit address without the R/W bit |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_code | output | 4 | Event type code |
| evt_value | output | 8 | Byte value for address/data events, else 0 |
| addr10 | output | 10 | Last assembled 10-bit slave address |
| addr10_valid | output | 1 | Pulses when a 10-bit address phase completes |

## Verification
Two functions can meet in one sample: an SCL rising edge and an SDA edge. If such a sample were taken as a START or STOP, a data bit would be lost and the transfer would be cut short. The bench drives SCL high and SDA changed in the same clock cycle, both in idle and inside a data byte. It is judged correct when idle produces no event and the data byte is reported with the bit that SDA carried after the change, with no STOP. A separate glitch test toggles SDA while SCL is high during the address byte and expects the address to be decoded as if nothing happened.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    typedef enum logic [1:0] {
        ST_FIND_START,
        ST_FIND_ADDR,
        ST_FIND_DATA,
        ST_FIND_ACK
    } mon_state_t;

    typedef enum logic [1:0] {
        DIR_NONE,
        DIR_WRITE,
        DIR_READ
    } xfer_dir_t;

    localparam int BYTE_W   = 8;
    localparam int ADDR10_W = 10;
    localparam int CODE_W   = 4;

    localparam logic [CODE_W-1:0] EV_START   = 4'd0;
    localparam logic [CODE_W-1:0] EV_RSTART  = 4'd1;
    localparam logic [CODE_W-1:0] EV_STOP    = 4'd2;
    localparam logic [CODE_W-1:0] EV_ACK     = 4'd3;
    localparam logic [CODE_W-1:0] EV_NACK    = 4'd4;
    localparam logic [CODE_W-1:0] EV_ADDR_RD = 4'd5;
    localparam logic [CODE_W-1:0] EV_ADDR_WR = 4'd6;
    localparam logic [CODE_W-1:0] EV_DATA_RD = 4'd7;
    localparam logic [CODE_W-1:0] EV_DATA_WR = 4'd8;

    // First-byte marker of a two-byte slave address (upper five bits).
    localparam logic [4:0] TEN_BIT_MARK = 5'b11110;

endpackage

// File: rtl/i2cmon_linesync.sv
module i2cmon_linesync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic level,
    output logic level_prev,
    output logic rise
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] chain;
    logic         prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= line_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[TOP-1:0], line_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain[TOP];
    end

    assign level      = chain[TOP];
    assign level_prev = prev_q;
    assign rise       = chain[TOP] & ~prev_q;

    // R2: a rising edge lasts exactly one system clock.
    a_r2_rise_single: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/i2cmon_cond_detect.sv
module i2cmon_cond_detect (
    input  logic scl_lvl,
    input  logic scl_prev,
    input  logic sda_lvl,
    input  logic sda_prev,
    output logic bit_edge,
    output logic start_cond,
    output logic stop_cond,
    output logic sda_bit
);
    logic scl_held_high;

    // SCL must be high in both samples: an SDA change that lands
    // together with an SCL rise is a data bit, not a condition.
    assign scl_held_high = scl_lvl & scl_prev;
    assign bit_edge      = scl_lvl & ~scl_prev;
    assign start_cond    = scl_held_high & sda_prev & ~sda_lvl;
    assign stop_cond     = scl_held_high & ~sda_prev & sda_lvl;
    assign sda_bit       = sda_lvl;

endmodule

// File: rtl/i2cmon_fsm.sv
module i2cmon_fsm
    import i2cmon_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_addr,
    input  logic                bit_edge,
    input  logic                start_cond,
    input  logic                stop_cond,
    input  logic                sda_bit,
    output logic                evt_valid,
    output logic [CODE_W-1:0]   evt_code,
    output logic [BYTE_W-1:0]   evt_value,
    output logic [ADDR10_W-1:0] addr10,
    output logic                addr10_valid
);
    localparam int BCNT_W = $clog2(BYTE_W);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W - 1);
    localparam int HI_W = ADDR10_W - BYTE_W;

    mon_state_t          state, state_nx;
    xfer_dir_t           dir, dir_nx, dir_eff;
    logic [BYTE_W-1:0]   shreg, shreg_nx, byte_full;
    logic [BCNT_W-1:0]   bitcnt, bitcnt_nx;
    logic                rep, rep_nx;
    logic [1:0]          rem, rem_nx, rem_left;
    logic                ten, ten_nx;
    logic [HI_W-1:0]     hi, hi_nx;
    logic [ADDR10_W-1:0] a10_q, a10_nx;
    logic                prefix_hit;

    logic                ev_fire, a10v_nx;
    logic [CODE_W-1:0]   ev_code_nx;
    logic [BYTE_W-1:0]   ev_val_nx;

    assign byte_full  = {shreg[BYTE_W-2:0], sda_bit};
    assign prefix_hit = (byte_full[BYTE_W-1:BYTE_W-5] == TEN_BIT_MARK);
    assign rem_left   = (rem == 2'd0) ? 2'd0 : rem - 2'd1;

    always_comb begin
        state_nx   = state;
        dir_nx     = dir;
        shreg_nx   = shreg;
        bitcnt_nx  = bitcnt;
        rep_nx     = rep;
        rem_nx     = rem;
        ten_nx     = ten;
        hi_nx      = hi;
        a10_nx     = a10_q;
        ev_fire    = 1'b0;
        ev_code_nx = EV_START;
        ev_val_nx  = '0;
        a10v_nx    = 1'b0;
        dir_eff    = dir;

        unique case (state)
            ST_FIND_START: begin
                if (start_cond) begin
                    ev_fire    = 1'b1;
                    ev_code_nx = rep ? EV_RSTART : EV_START;
                    rep_nx     = 1'b1;
                    dir_nx     = DIR_NONE;
                    rem_nx     = 2'd0;
                    ten_nx     = 1'b0;
                    bitcnt_nx  = '0;
                    state_nx   = ST_FIND_ADDR;
                end
            end

            ST_FIND_ADDR: begin
                if (bit_edge) begin
                    shreg_nx = byte_full;
                    if (bitcnt == LAST_BIT) begin
                        bitcnt_nx = '0;
                        state_nx  = ST_FIND_ACK;
                        if (dir == DIR_NONE)
                            dir_eff = byte_full[0] ? DIR_READ : DIR_WRITE;
                        dir_nx     = dir_eff;
                        ev_fire    = 1'b1;
                        ev_code_nx = (dir_eff == DIR_READ) ? EV_ADDR_RD : EV_ADDR_WR;
                        if (rem == 2'd0) begin
                            if (prefix_hit) begin
                                rem_nx    = 2'd2;
                                ten_nx    = 1'b1;
                                hi_nx     = byte_full[HI_W:1];
                                ev_val_nx = byte_full;
                            end else begin
                                rem_nx    = 2'd1;
                                ten_nx    = 1'b0;
                                ev_val_nx = shift_addr ? (byte_full >> 1) : byte_full;
                            end
                        end else begin
                            a10_nx    = {hi, byte_full};
                            ev_val_nx = byte_full;
                        end
                    end else begin
                        bitcnt_nx = bitcnt + 1'b1;
                    end
                end
            end

            ST_FIND_ACK: begin
                if (bit_edge) begin
                    ev_fire    = 1'b1;
                    ev_code_nx = sda_bit ? EV_NACK : EV_ACK;
                    rem_nx     = rem_left;
                    a10v_nx    = ten && (rem == 2'd1);
                    state_nx   = (rem_left != 2'd0) ? ST_FIND_ADDR : ST_FIND_DATA;
                end
            end

            ST_FIND_DATA: begin
                if (bit_edge) begin
                    shreg_nx = byte_full;
                    if (bitcnt == LAST_BIT) begin
                        bitcnt_nx  = '0;
                        state_nx   = ST_FIND_ACK;
                        ev_fire    = 1'b1;
                        ev_code_nx = (dir == DIR_READ) ? EV_DATA_RD : EV_DATA_WR;
                        ev_val_nx  = byte_full;
                    end else begin
                        bitcnt_nx = bitcnt + 1'b1;
                    end
                end else if (start_cond) begin
                    ev_fire    = 1'b1;
                    ev_code_nx = rep ? EV_RSTART : EV_START;
                    rep_nx     = 1'b1;
                    dir_nx     = DIR_NONE;
                    rem_nx     = 2'd0;
                    ten_nx     = 1'b0;
                    bitcnt_nx  = '0;
                    state_nx   = ST_FIND_ADDR;
                end else if (stop_cond) begin
                    ev_fire    = 1'b1;
                    ev_code_nx = EV_STOP;
                    rep_nx     = 1'b0;
                    dir_nx     = DIR_NONE;
                    rem_nx     = 2'd0;
                    ten_nx     = 1'b0;
                    bitcnt_nx  = '0;
                    state_nx   = ST_FIND_START;
                end
            end

            default: state_nx = ST_FIND_START;
        endcase
    end

    // State register and transfer context.
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_FIND_START;
            dir    <= DIR_NONE;
            shreg  <= '0;
            bitcnt <= '0;
            rep    <= 1'b0;
            rem    <= 2'd0;
            ten    <= 1'b0;
            hi     <= '0;
            a10_q  <= '0;
        end else begin
            state  <= state_nx;
            dir    <= dir_nx;
            shreg  <= shreg_nx;
            bitcnt <= bitcnt_nx;
            rep    <= rep_nx;
            rem    <= rem_nx;
            ten    <= ten_nx;
            hi     <= hi_nx;
            a10_q  <= a10_nx;
        end
    end

    // Registered event outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_valid    <= 1'b0;
            evt_code     <= EV_START;
            evt_value    <= '0;
            addr10_valid <= 1'b0;
        end else begin
            evt_valid    <= ev_fire;
            evt_code     <= ev_code_nx;
            evt_value    <= ev_val_nx;
            addr10_valid <= a10v_nx;
        end
    end

    assign addr10 = a10_q;

    a_r3_start_opens: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && (evt_code == EV_START || evt_code == EV_RSTART))
            |-> (state == ST_FIND_ADDR && rep && bitcnt == '0));

    a_r3_stop_closes: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_code == EV_STOP) |-> (state == ST_FIND_START && !rep));

    a_r4_ack_next_state: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && (evt_code == EV_ACK || evt_code == EV_NACK))
            |-> (state == ST_FIND_ADDR || state == ST_FIND_DATA));

    a_r5_byte_awaits_ack: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_code >= EV_ADDR_RD) |-> (state == ST_FIND_ACK));

    a_r5_code_range: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (evt_code <= EV_DATA_WR));

    a_r8_addr_with_ack: assert property (@(posedge clk) disable iff (rst)
        addr10_valid |-> (evt_valid && (evt_code == EV_ACK || evt_code == EV_NACK)
                          && state == ST_FIND_DATA));

    a_r10_data_after_addr: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_code >= EV_DATA_RD) |-> $past(state) == ST_FIND_DATA);

endmodule

// File: rtl/i2c_bus_observer.sv
module i2c_bus_observer
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic                shift_addr,
    output logic                evt_valid,
    output logic [CODE_W-1:0]   evt_code,
    output logic [BYTE_W-1:0]   evt_value,
    output logic [ADDR10_W-1:0] addr10,
    output logic                addr10_valid
);
    logic scl_lvl, scl_prev, scl_rise;
    logic sda_lvl, sda_prev, sda_rise;
    logic bit_edge, start_cond, stop_cond, sda_bit;

    i2cmon_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .line_in(scl_in),
        .level(scl_lvl), .level_prev(scl_prev), .rise(scl_rise)
    );

    i2cmon_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .line_in(sda_in),
        .level(sda_lvl), .level_prev(sda_prev), .rise(sda_rise)
    );

    i2cmon_cond_detect u_cond (
        .scl_lvl(scl_lvl), .scl_prev(scl_prev),
        .sda_lvl(sda_lvl), .sda_prev(sda_prev),
        .bit_edge(bit_edge), .start_cond(start_cond),
        .stop_cond(stop_cond), .sda_bit(sda_bit)
    );

    i2cmon_fsm u_fsm (
        .clk(clk), .rst(rst), .shift_addr(shift_addr),
        .bit_edge(bit_edge), .start_cond(start_cond),
        .stop_cond(stop_cond), .sda_bit(sda_bit),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_value(evt_value),
        .addr10(addr10), .addr10_valid(addr10_valid)
    );

    // R2: the condition decoder and the synchroniser agree on SCL edges.
    a_r2_edge_agrees: assert property (@(posedge clk) disable iff (rst)
        scl_rise == bit_edge);

    // R2: a STOP on SDA is always seen as an SDA rising edge.
    a_r2_stop_needs_rise: assert property (@(posedge clk) disable iff (rst)
        stop_cond |-> sda_rise);

endmodule

// File: tb/i2c_bus_observer_tb.sv
module i2c_bus_observer_tb;
    localparam int PH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic shift_addr = 1'b1;

    logic       evt_valid;
    logic [3:0] evt_code;
    logic [7:0] evt_value;
    logic [9:0] addr10;
    logic       addr10_valid;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [3:0] got_code[$];
    logic [7:0] got_val[$];
    logic [3:0] exp_code[$];
    logic [7:0] exp_val[$];
    int a10_pulses = 0;
    int a10_pulse_evt = -1;

    always #2 clk = ~clk;

    i2c_bus_observer u_dut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
        .shift_addr(shift_addr),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_value(evt_value),
        .addr10(addr10), .addr10_valid(addr10_valid)
    );

    always @(negedge clk) begin
        if (!rst && evt_valid) begin
            got_code.push_back(evt_code);
            got_val.push_back(evt_value);
        end
        if (!rst && addr10_valid) begin
            a10_pulses++;
            a10_pulse_evt = evt_valid ? int'(evt_code) : -1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_log();
        got_code.delete(); got_val.delete();
        exp_code.delete(); exp_val.delete();
        a10_pulses = 0; a10_pulse_evt = -1;
    endtask

    task automatic expect_evt(input logic [3:0] c, input logic [7:0] v);
        exp_code.push_back(c);
        exp_val.push_back(v);
    endtask

    task automatic compare_log(input string req);
        tick(12);
        chk(got_code.size() == exp_code.size(), req, "event count",
            got_code.size(), exp_code.size());
        for (int i = 0; i < exp_code.size() && i < got_code.size(); i++) begin
            chk(got_code[i] == exp_code[i], req, $sformatf("code[%0d]", i),
                got_code[i], exp_code[i]);
            chk(got_val[i] == exp_val[i], req, $sformatf("value[%0d]", i),
                got_val[i], exp_val[i]);
        end
    endtask

    task automatic bus_start();
        sda = 1'b1; tick(PH);
        scl = 1'b1; tick(PH);
        sda = 1'b0; tick(PH);
        scl = 1'b0; tick(PH);
    endtask

    task automatic bus_stop();
        sda = 1'b0; tick(PH);
        scl = 1'b1; tick(PH);
        sda = 1'b1; tick(PH);
    endtask

    task automatic send_bit(input logic b);
        sda = b;    tick(PH);
        scl = 1'b1; tick(PH);
        scl = 1'b0; tick(PH);
    endtask

    // SDA toggles low then high while SCL is high: START-then-STOP shape.
    task automatic send_bit_glitch();
        sda = 1'b1; tick(PH);
        scl = 1'b1; tick(PH);
        sda = 1'b0; tick(PH);
        sda = 1'b1; tick(PH);
        scl = 1'b0; tick(PH);
    endtask

    // SDA takes its new value in the same cycle as SCL rises.
    task automatic send_bit_simul(input logic b);
        sda = ~b;   tick(PH);
        sda = b; scl = 1'b1; tick(PH);
        scl = 1'b0; tick(PH);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic nack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        send_bit(nack);
    endtask

    // R1, R10: reset state, and SCL pulses in idle give nothing.
    task automatic t_reset_idle();
        clear_log();
        chk(evt_valid == 1'b0, "R1", "evt_valid after reset", evt_valid, 0);
        chk(addr10 == 10'h0, "R1", "addr10 after reset", addr10, 0);
        chk(addr10_valid == 1'b0, "R1", "addr10_valid after reset", addr10_valid, 0);
        for (int k = 0; k < 3; k++) begin
            scl = 1'b0; tick(PH);
            sda = ~sda; tick(PH);
            scl = 1'b1; tick(PH);
        end
        sda = 1'b1; tick(PH);
        compare_log("R1");
    endtask

    // R2, R3, R4, R5, R6: 7-bit write, shifted, ends with NACK.
    task automatic t_write7_shifted();
        clear_log();
        shift_addr = 1'b1;
        bus_start();
        send_byte(8'hA2, 1'b0);
        send_byte(8'h3C, 1'b0);
        send_byte(8'h5A, 1'b1);
        bus_stop();
        expect_evt(4'd0, 8'h00);
        expect_evt(4'd6, 8'h51);
        expect_evt(4'd3, 8'h00);
        expect_evt(4'd8, 8'h3C);
        expect_evt(4'd3, 8'h00);
        expect_evt(4'd8, 8'h5A);
        expect_evt(4'd4, 8'h00);
        expect_evt(4'd2, 8'h00);
        compare_log("R6");
        chk(a10_pulses == 0, "R8", "addr10_valid on 7-bit", a10_pulses, 0);
    endtask

    // R3, R5, R6: unshifted read, repeated START switches direction.
    task automatic t_read7_restart();
        clear_log();
        shift_addr = 1'b0;
        bus_start();
        send_byte(8'hA3, 1'b0);
        send_byte(8'h96, 1'b1);
        bus_start();
        send_byte(8'hA2, 1'b0);
        bus_stop();
        expect_evt(4'd0, 8'h00);
        expect_evt(4'd5, 8'hA3);
        expect_evt(4'd3, 8'h00);
        expect_evt(4'd7, 8'h96);
        expect_evt(4'd4, 8'h00);
        expect_evt(4'd1, 8'h00);
        expect_evt(4'd6, 8'hA2);
        expect_evt(4'd3, 8'h00);
        expect_evt(4'd2, 8'h00);
        compare_log("R3");
    endtask

    // R7, R8: 10-bit write, shift mode on but 10-bit bytes stay raw.
    task automatic t_write10();
        clear_log();
        shift_addr = 1'b1;
        bus_start();
        send_byte(8'hF6, 1'b0);
        send_byte(8'h5C, 1'b0);
        send_byte(8'h11, 1'b0);
        bus_stop();
        expect_evt(4'd0, 8'h00);
        expect_evt(4'd6, 8'hF6);
        expect_evt(4'd3, 8'h00);
        expect_evt(4'd6, 8'h5C);
        expect_evt(4'd3, 8'h00);
        expect_evt(4'd8, 8'h11);
        expect_evt(4'd3, 8'h00);
        expect_evt(4'd2, 8'h00);
        compare_log("R7");
        chk(addr10 == 10'h35C, "R8", "addr10 write", addr10, 10'h35C);
        chk(a10_pulses == 1, "R8", "addr10_valid pulses", a10_pulses, 1);
        chk(a10_pulse_evt == 3, "R8", "event with addr10_valid", a10_pulse_evt, 3);
    endtask

    // R5, R7, R8: 10-bit read, second address byte labelled read.
    task automatic t_read10();
        clear_log();
        shift_addr = 1'b1;
        bus_start();
        send_byte(8'hF3, 1'b0);
        send_byte(8'h02, 1'b0);
        send_byte(8'hE7, 1'b1);
        bus_stop();
        expect_evt(4'd0, 8'h00);
        expect_evt(4'd5, 8'hF3);
        expect_evt(4'd3, 8'h00);
        expect_evt(4'd5, 8'h02);
        expect_evt(4'd3, 8'h00);
        expect_evt(4'd7, 8'hE7);
        expect_evt(4'd4, 8'h00);
        expect_evt(4'd2, 8'h00);
        compare_log("R5");
        chk(addr10 == 10'h102, "R8", "addr10 read", addr10, 10'h102);
        chk(a10_pulses == 1, "R8", "addr10_valid pulses read", a10_pulses, 1);
    endtask

    // R9: START/STOP shapes inside the address byte are ignored.
    task automatic t_addr_glitch();
        clear_log();
        shift_addr = 1'b1;
        bus_start();
        send_bit_glitch();
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        send_bit(1'b0);
        bus_stop();
        expect_evt(4'd0, 8'h00);
        expect_evt(4'd6, 8'h48);
        expect_evt(4'd3, 8'h00);
        expect_evt(4'd2, 8'h00);
        compare_log("R9");
    endtask

    // R2, R10: SCL rise together with an SDA edge is a bit, not a condition.
    task automatic t_same_cycle();
        clear_log();
        shift_addr = 1'b0;
        scl = 1'b0; tick(PH);
        sda = 1'b0; scl = 1'b1; tick(PH);
        scl = 1'b0; tick(PH);
        sda = 1'b1; tick(PH);
        scl = 1'b1; tick(PH);
        compare_log("R2");
        clear_log();
        bus_start();
        send_byte(8'h40, 1'b0);
        send_bit_simul(1'b1);
        for (int i = 6; i >= 0; i--) send_bit(1'b0);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        bus_stop();
        expect_evt(4'd0, 8'h00);
        expect_evt(4'd6, 8'h40);
        expect_evt(4'd3, 8'h00);
        expect_evt(4'd8, 8'h80);
        expect_evt(4'd3, 8'h00);
        expect_evt(4'd2, 8'h00);
        compare_log("R10");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(6);
        rst = 1'b0;
        tick(4);
        t_reset_idle();
        t_write7_shifted();
        t_read7_restart();
        t_write10();
        t_read10();
        t_addr_glitch();
        t_same_cycle();
        finish_run();
    end

endmodule